// File: doc/BRIEF.md
# Two-Channel Class-D PWM Modulator with Duty Ceiling

This block turns two signed audio sample words into bridge drive bits for two H-bridges. A free-running carrier counter of `PERIOD` system-clock cycles sets the switching rate. With the default of 480 cycles and a 125 MHz clock, the rate is about 260 kHz.

Each bridge has a positive half and a negative half. Both halves turn on at the start of every carrier period. The positive half stays on longer than half a period when the scaled sample is positive, and the negative half stays on for the same amount less. With a zero sample, both halves run in phase at 50 percent, so the differential output is zero.

A gain select scales each sample, and the result saturates to the sample width. A limit code then bounds how far the duty may move from the centre. This acts as a lower virtual supply rail. The top half of the code range turns the bound off.

A parallel mode drives a single speaker across the two bridges from the right-channel sample. In this mode, the two halves of each bridge switch together. Sample, gain, limit and mode are captured only at a carrier boundary, so a pulse never gets cut short or split mid-period.

Top module: `pwm_bridge_mod`

## Requirements
- R1: While `rst_n` is low, all four drive bits and both bits of `out_en` are 0.
- R2: The carrier period is `PERIOD` clock cycles. The carrier phase is 0 in the first cycle after reset is released. An active drive bit is high exactly for phases 0 to on-1 of each period, where on is its on-count, so any rising edge falls only on phase 0.
- R3: A zero sample gives both halves of a bridge an on-count of `PERIOD/2`, in phase.
- R4: Let y be the gained and saturated sample. Then d = floor(y*HALF / 2^(W-1)), with HALF = `PERIOD/2`. The positive-half on-count is HALF+d and the negative-half on-count is HALF-d.
- R5: `gain_sel` multiplies the sample by 10 (code 00), 20 (01), 40 (10) or 63 (11).
- R6: The gained value saturates to the signed W-bit range before it is scaled.
- R7: If `lim_code` < 2^(LIM_W-1), d is clamped to the range ±floor(`lim_code`*HALF / 2^(LIM_W-1)).
- R8: If `lim_code` ≥ 2^(LIM_W-1), no clamp is applied.
- R9: With `par_mode`=0, the left bridge follows only `samp_l` and the right bridge follows only `samp_r`.
- R10: With `par_mode`=1, both left halves use HALF+d and both right halves use HALF-d, with d taken from `samp_r`. `samp_l` has no effect.
- R11: Inputs are captured at the clock edge that ends phase `PERIOD-1`. A change during a period does not alter that period's pulses.
- R12: When `enable` goes low, all drive bits and `out_en` go low at the next clock edge. When `enable` goes high, `out_en` becomes 2'b11 at the next carrier boundary (bit 0 is left, bit 1 is right).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run request for the output stages |
| par_mode | input | 1 | 1 selects parallel-bridge mono mode |
| gain_sel | input | 2 | Gain code |
| lim_code | input | LIM_W | Duty ceiling code |
| samp_l | input | W | Left signed sample |
| samp_r | input | W | Right signed sample |
| drv_lp | output | 1 | Left bridge positive-half drive |
| drv_ln | output | 1 | Left bridge negative-half drive |
| drv_rp | output | 1 | Right bridge positive-half drive |
| drv_rn | output | 1 | Right bridge negative-half drive |
| out_en | output | 2 | Output stage enable, bit 0 left, bit 1 right |

## Verification
A wrong carrier count or a wrongly captured on-count shows within one carrier period. It appears as a drive bit whose high time is wrong or whose rising edge is off phase 0. The bench therefore compares every cycle of a full period for all four outputs against on-counts computed from the requirements. A capture that happens at the wrong time shows up when a sample changes mid-period and the current pulse changes length. A run flag that is stuck shows one cycle after `enable` falls, or at the first boundary after it rises.

// File: rtl/pwm_bridge_mod.sv
module pwm_bridge_mod #(
  parameter int W      = 16,
  parameter int LIM_W  = 8,
  parameter int PERIOD = 480
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enable,
  input  logic                par_mode,
  input  logic [1:0]          gain_sel,
  input  logic [LIM_W-1:0]    lim_code,
  input  logic signed [W-1:0] samp_l,
  input  logic signed [W-1:0] samp_r,
  output logic                drv_lp,
  output logic                drv_ln,
  output logic                drv_rp,
  output logic                drv_rn,
  output logic [1:0]          out_en
);
  localparam int     OW    = $clog2(PERIOD + 1);
  localparam int     HALF  = PERIOD / 2;
  localparam longint HALFL = longint'(HALF);
  localparam longint MAXV  = (longint'(1) <<< (W - 1)) - 1;
  localparam longint MINV  = -(longint'(1) <<< (W - 1));
  localparam longint LFULL = longint'(1) <<< (LIM_W - 1);

  function automatic longint lim_span(input logic [LIM_W-1:0] lim);
    if (longint'(lim) >= LFULL) return HALFL;
    return (longint'(lim) * HALFL) >>> (LIM_W - 1);
  endfunction

  function automatic longint offs(input logic signed [W-1:0] s, input logic [1:0] g,
                                  input logic [LIM_W-1:0] lim);
    longint c, y, d, m;
    case (g)
      2'd0:    c = 10;
      2'd1:    c = 20;
      2'd2:    c = 40;
      default: c = 63;
    endcase
    y = longint'(s) * c;
    if (y > MAXV) y = MAXV;
    else if (y < MINV) y = MINV;
    d = (y * HALFL) >>> (W - 1);
    m = lim_span(lim);
    if (d > m) d = m;
    else if (d < -m) d = -m;
    return d;
  endfunction

  logic [OW-1:0] cnt, lp_q, ln_q, rp_q, rn_q, span_q;
  logic          run, par_q;
  logic          wrap;
  longint        dl, dr;

  assign wrap = (cnt == OW'(PERIOD - 1));
  assign dl   = offs(samp_l, gain_sel, lim_code);
  assign dr   = offs(samp_r, gain_sel, lim_code);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      run    <= 1'b0;
      par_q  <= 1'b0;
      lp_q   <= OW'(HALF);
      ln_q   <= OW'(HALF);
      rp_q   <= OW'(HALF);
      rn_q   <= OW'(HALF);
      span_q <= OW'(HALF);
    end else begin
      cnt <= wrap ? '0 : cnt + 1'b1;
      if (!enable)   run <= 1'b0;
      else if (wrap) run <= 1'b1;
      if (wrap) begin
        par_q  <= par_mode;
        span_q <= OW'(lim_span(lim_code));
        if (par_mode) begin
          lp_q <= OW'(HALFL + dr);
          ln_q <= OW'(HALFL + dr);
          rp_q <= OW'(HALFL - dr);
          rn_q <= OW'(HALFL - dr);
        end else begin
          lp_q <= OW'(HALFL + dl);
          ln_q <= OW'(HALFL - dl);
          rp_q <= OW'(HALFL + dr);
          rn_q <= OW'(HALFL - dr);
        end
      end
    end
  end

  assign out_en = {run, run};
  assign drv_lp = run && (cnt < lp_q);
  assign drv_ln = run && (cnt < ln_q);
  assign drv_rp = run && (cnt < rp_q);
  assign drv_rn = run && (cnt < rn_q);

  a_r2_rise_on_phase0: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(drv_lp) || $rose(drv_ln) || $rose(drv_rp) || $rose(drv_rn)) |-> (cnt == '0));

  a_r12_fast_off: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (out_en == 2'b00));

  a_r12_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (out_en == 2'b00) |-> !(drv_lp || drv_ln || drv_rp || drv_rn));

  a_r7_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !par_q && ({1'b0, cnt} >= ({1'b0, OW'(HALF)} + {1'b0, span_q})))
      |-> !(drv_lp || drv_rp));

  a_r10_in_phase: assert property (@(posedge clk) disable iff (!rst_n)
    (run && par_q) |-> ((drv_lp == drv_ln) && (drv_rp == drv_rn)));

  a_r4_symmetric: assert property (@(posedge clk) disable iff (!rst_n)
    !par_q |-> (({1'b0, lp_q} + {1'b0, ln_q}) == (OW + 1)'(PERIOD)));

  a_r11_hold_mid_period: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0) |-> ($stable(lp_q) && $stable(ln_q) && $stable(rp_q) && $stable(rn_q)));
endmodule

// File: tb/pwm_bridge_mod_tb.sv
`timescale 1ns/1ps
module pwm_bridge_mod_tb;
  localparam int W = 16, LIM_W = 8, P = 40, HALF = P / 2;

  logic clk = 1'b0, rst_n = 1'b0, enable = 1'b0, par_mode = 1'b0;
  logic [1:0] gain_sel = 2'd0;
  logic [LIM_W-1:0] lim_code = 8'd255;
  logic signed [W-1:0] samp_l = '0, samp_r = '0;
  logic drv_lp, drv_ln, drv_rp, drv_rn;
  logic [1:0] out_en;
  int total = 0, fails = 0, ph = 0;
  bit done = 0;

  pwm_bridge_mod #(.W(W), .LIM_W(LIM_W), .PERIOD(P)) u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .par_mode(par_mode),
    .gain_sel(gain_sel), .lim_code(lim_code), .samp_l(samp_l), .samp_r(samp_r),
    .drv_lp(drv_lp), .drv_ln(drv_ln), .drv_rp(drv_rp), .drv_rn(drv_rn), .out_en(out_en));

  always #4 clk = ~clk;
  always @(posedge clk) ph <= !rst_n ? 0 : (ph == P - 1 ? 0 : ph + 1);

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int ref_d(input int s, input int g, input int lim);
    int c, y, d, m;
    c = (g == 0) ? 10 : (g == 1) ? 20 : (g == 2) ? 40 : 63;
    y = s * c;
    if (y > 32767) y = 32767;
    if (y < -32768) y = -32768;
    d = (y * HALF) >>> (W - 1);
    m = (lim >= 128) ? HALF : (lim * HALF) >>> (LIM_W - 1);
    if (d > m) d = m;
    if (d < -m) d = -m;
    return d;
  endfunction

  task automatic to_phase(input int k);
    @(negedge clk);
    while (ph != k) @(negedge clk);
  endtask

  task automatic measure(input string tag, input int elp, input int eln, input int erp, input int ern);
    int hlp = 0, hln = 0, hrp = 0, hrn = 0, bad = 0;
    to_phase(0);
    for (int k = 0; k < P; k++) begin
      hlp += drv_lp; hln += drv_ln; hrp += drv_rp; hrn += drv_rn;
      if (drv_lp != (k < elp) || drv_ln != (k < eln) || drv_rp != (k < erp) || drv_rn != (k < ern)) bad++;
      if (k < P - 1) @(negedge clk);
    end
    chk({tag, " lp"}, hlp, elp);
    chk({tag, " ln"}, hln, eln);
    chk({tag, " rp"}, hrp, erp);
    chk({tag, " rn"}, hrn, ern);
    chk({tag, " R2 placement"}, bad, 0);
  endtask

  task automatic run_normal(input string tag, input int sl, input int sr, input int g, input int lim);
    int dl, dr;
    samp_l = W'(sl); samp_r = W'(sr); gain_sel = 2'(g); lim_code = LIM_W'(lim); par_mode = 0;
    dl = ref_d(sl, g, lim); dr = ref_d(sr, g, lim);
    measure(tag, HALF + dl, HALF - dl, HALF + dr, HALF - dr);
  endtask

  task automatic t_reset;
    chk("R1 out_en", int'(out_en), 0);
    chk("R1 drives", int'({drv_lp, drv_ln, drv_rp, drv_rn}), 0);
  endtask

  task automatic t_parallel;
    int d;
    par_mode = 1; samp_r = 16'sd1000; samp_l = -16'sd3000; gain_sel = 0; lim_code = 8'd255;
    d = ref_d(1000, 0, 255);
    measure("R10 parallel", HALF + d, HALF + d, HALF - d, HALF - d);
    samp_l = 16'sd3000;
    measure("R10 left ignored", HALF + d, HALF + d, HALF - d, HALF - d);
    par_mode = 0;
  endtask

  task automatic t_midperiod;
    int dA, dB, hit = 0;
    run_normal("R11 setup", 100, 100, 0, 255);
    dA = ref_d(100, 0, 255); dB = ref_d(2000, 0, 255);
    to_phase(10);
    samp_l = 16'sd2000;
    for (int k = 10; k < P; k++) begin
      hit += drv_lp;
      if (k < P - 1) @(negedge clk);
    end
    chk("R11 rest of period unchanged", hit, (HALF + dA > 10) ? HALF + dA - 10 : 0);
    measure("R11 next period", HALF + dB, HALF - dB, HALF + dA, HALF - dA);
  endtask

  task automatic t_enable;
    samp_l = 0; samp_r = 0;
    to_phase(5);
    enable = 0;
    @(negedge clk);
    chk("R12 out_en off next cycle", int'(out_en), 0);
    chk("R12 drives off next cycle", int'({drv_lp, drv_ln, drv_rp, drv_rn}), 0);
    to_phase(15);
    enable = 1;
    @(negedge clk);
    chk("R12 waits for boundary", int'(out_en), 0);
    to_phase(0);
    chk("R12 on at boundary", int'(out_en), 3);
    chk("R12 drives at phase0", int'({drv_lp, drv_ln, drv_rp, drv_rn}), 15);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1; enable = 1;
    measure("R3 zero input", HALF, HALF, HALF, HALF);
    run_normal("R4 R5 gain00 pos", 1000, 0, 0, 255);
    run_normal("R4 R5 gain01 neg", -1000, 0, 1, 255);
    run_normal("R5 R6 gain11 sat pos", 1000, -200, 3, 255);
    run_normal("R5 R6 gain10 sat neg", -900, 300, 2, 255);
    run_normal("R7 limit pos", 2000, -2000, 0, 64);
    run_normal("R7 limit zero", 2000, -500, 1, 0);
    run_normal("R8 no limit", 2000, -2000, 0, 200);
    run_normal("R9 independent", 700, -1500, 1, 255);
    t_parallel();
    t_midperiod();
    t_enable();
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog expired R2 actual 0 expected 1");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule